// File: doc/BRIEF.md
# Host Access Lock Gate

This block stands on the host register path in front of a group of shared peripheral modules. Each module has its own lock bit, and a local controller sets or clears it. While a module's lock is clear, host reads and writes go through to that module unchanged. While the lock is set, the gate stops the access. A blocked write never reaches the module. A blocked read completes with zero data. In both cases the host still gets a normal acknowledge, so it never stalls.

Each blocked attempt raises a sticky violation flag for the module concerned. The controller reads these flags and clears them by writing ones. The intended use has three steps. The controller locks a module before it works on it. It then does its own register work. Finally it clears the lock, which returns the module to the host.

The module is selected from the upper `IDX_W` bits of the host address. An index below `NUM_MOD` selects that module. An index at or above `NUM_MOD` maps to no module and passes through without any lock check.

Top module: `host_lock_gate`

## Requirements
- R1: After reset, every lock bit and every violation bit is 0.
- R2: A host access to an unlocked module is forwarded in the same cycle. The forwarded request keeps the same write flag, address and write data. `p_sel` is one-hot, with bit i set for the module whose index is `h_addr[ADDR_W-1 -: IDX_W]`. `h_ack` and `h_rdata` follow `p_ack` and `p_rdata`.
- R3: A host write to a locked module is not forwarded (`p_req` stays 0), and the module's contents stay unchanged. `h_ack` is asserted in the cycle after the request.
- R4: A host read from a locked module is not forwarded. It completes with `h_ack` in the cycle after the request, and `h_rdata` is 0 in that cycle.
- R5: A blocked host access sets the violation bit of the addressed module in the cycle after the request.
- R6: Violation bits are sticky. A bit is cleared only by a 1 in the same position of `c_viol_clr`, and bits at 0 in `c_viol_clr` are left as they are.
- R7: If a clear pulse and a new blocked access hit the same violation bit in the same cycle, the bit ends up set.
- R8: An address whose index is `NUM_MOD` or above is forwarded with `p_sel` all zero, whatever the locks hold, and never sets a violation bit.
- R9: When `c_lock_we` is high, the lock vector loads `c_lock_wdata` at the next clock edge. Host requests see the new value from that edge onward.
- R10: Locks act per module: a lock on one module does not block accesses to any other module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | ADDR_W | Host address; upper IDX_W bits select the module |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Read data returned to the host |
| h_ack | output | 1 | Access complete, to the host |
| p_req | output | 1 | Forwarded access strobe to the modules |
| p_we | output | 1 | Forwarded write flag |
| p_addr | output | ADDR_W | Forwarded address |
| p_wdata | output | DATA_W | Forwarded write data |
| p_sel | output | NUM_MOD | One-hot module select of the forwarded access |
| p_rdata | input | DATA_W | Read data from the modules |
| p_ack | input | 1 | Completion from the modules |
| c_lock_we | input | 1 | Controller load strobe for the lock vector |
| c_lock_wdata | input | NUM_MOD | New lock vector |
| lock | output | NUM_MOD | Current lock bits |
| c_viol_clr | input | NUM_MOD | Write-one-to-clear mask for violation bits |
| viol | output | NUM_MOD | Sticky violation bits |

## Verification
The hardest case to reach is a blocked access that lands on a violation bit in the same cycle as a controller clear of that bit. The host path and the controller path are normally driven one after the other. To create the collision, the stimulus first sets the bit with one blocked access. It then drives a second blocked host request and the clear mask on the same falling edge. A second hard case is showing that a dropped write left nothing behind. For this, the bench reads the same address back after the unlock and expects the value written before the lock.

// File: rtl/host_lock_gate.sv
module host_lock_gate #(
  parameter int NUM_MOD = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_req,
  input  logic               h_we,
  input  logic [ADDR_W-1:0]  h_addr,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               h_ack,
  output logic               p_req,
  output logic               p_we,
  output logic [ADDR_W-1:0]  p_addr,
  output logic [DATA_W-1:0]  p_wdata,
  output logic [NUM_MOD-1:0] p_sel,
  input  logic [DATA_W-1:0]  p_rdata,
  input  logic               p_ack,
  input  logic               c_lock_we,
  input  logic [NUM_MOD-1:0] c_lock_wdata,
  output logic [NUM_MOD-1:0] lock,
  input  logic [NUM_MOD-1:0] c_viol_clr,
  output logic [NUM_MOD-1:0] viol
);

  logic [IDX_W-1:0]   idx;
  logic [NUM_MOD-1:0] hit;
  logic [NUM_MOD-1:0] lock_q;
  logic [NUM_MOD-1:0] viol_q;
  logic               blocked;
  logic               blk_ack_q;

  assign idx = h_addr[ADDR_W-1 -: IDX_W];

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_dec
    assign hit[i] = (idx == IDX_W'(i));
  end

  assign blocked = h_req & |(hit & lock_q);

  assign p_req   = h_req & ~blocked;
  assign p_we    = h_we;
  assign p_addr  = h_addr;
  assign p_wdata = h_wdata;
  assign p_sel   = p_req ? hit : '0;

  assign h_ack   = p_ack | blk_ack_q;
  assign h_rdata = blk_ack_q ? '0 : p_rdata;

  assign lock = lock_q;
  assign viol = viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= '0;
      viol_q    <= '0;
      blk_ack_q <= 1'b0;
    end else begin
      if (c_lock_we) lock_q <= c_lock_wdata;
      viol_q    <= (viol_q & ~c_viol_clr) | (blocked ? hit : '0);
      blk_ack_q <= blocked;
    end
  end

endmodule

// File: rtl/host_lock_gate_chk.sv
module host_lock_gate_chk #(
  parameter int NUM_MOD = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_req,
  input logic               h_we,
  input logic [ADDR_W-1:0]  h_addr,
  input logic [DATA_W-1:0]  h_rdata,
  input logic               h_ack,
  input logic               p_req,
  input logic [NUM_MOD-1:0] p_sel,
  input logic [NUM_MOD-1:0] lock,
  input logic [NUM_MOD-1:0] c_viol_clr,
  input logic [NUM_MOD-1:0] viol
);

  logic [NUM_MOD-1:0] tgt;
  logic               mapped;
  logic               locked_hit;

  always_comb begin
    tgt = '0;
    for (int i = 0; i < NUM_MOD; i++)
      if (int'(h_addr[ADDR_W-1 -: IDX_W]) == i) tgt[i] = 1'b1;
  end
  assign mapped     = |tgt;
  assign locked_hit = h_req && |(tgt & lock);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (lock == '0 && viol == '0));

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_sel));

  a_r3_no_forward_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked_hit |-> !p_req);

  a_r4_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_hit && !h_we) |=> (h_ack && h_rdata == '0));

  a_r5_viol_raised: assert property (@(posedge clk) disable iff (!rst_n)
    locked_hit |=> ((viol & $past(tgt)) == $past(tgt)));

  a_r6_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((viol & $past(viol & ~c_viol_clr)) == $past(viol & ~c_viol_clr)));

  a_r8_unmapped_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !mapped) |-> (p_req && p_sel == '0));

  a_r10_unlocked_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && mapped && !locked_hit) |-> (p_req && p_sel == tgt));

endmodule

bind host_lock_gate host_lock_gate_chk #(
  .NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
  .h_rdata(h_rdata), .h_ack(h_ack), .p_req(p_req), .p_sel(p_sel),
  .lock(lock), .c_viol_clr(c_viol_clr), .viol(viol)
);

// File: tb/host_lock_gate_tb.sv
`timescale 1ns/1ps
module host_lock_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_req = 1'b0, h_we = 1'b0;
  logic [7:0] h_addr = '0, h_wdata = '0;
  logic [7:0] h_rdata;
  logic       h_ack;
  logic       p_req, p_we;
  logic [7:0] p_addr, p_wdata;
  logic [3:0] p_sel;
  logic [7:0] p_rdata = '0;
  logic       p_ack = 1'b0;
  logic       c_lock_we = 1'b0;
  logic [3:0] c_lock_wdata = '0;
  logic [3:0] lock;
  logic [3:0] c_viol_clr = '0;
  logic [3:0] viol;

  int nchecks = 0;
  int nfail   = 0;

  always #2 clk = ~clk;

  host_lock_gate u_dut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .p_req(p_req),
    .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_sel(p_sel),
    .p_rdata(p_rdata), .p_ack(p_ack), .c_lock_we(c_lock_we),
    .c_lock_wdata(c_lock_wdata), .lock(lock), .c_viol_clr(c_viol_clr),
    .viol(viol)
  );

  logic [7:0] pmem [256];
  logic [7:0] exp_mem [256];
  logic [3:0] m_lock = '0;

  initial for (int i = 0; i < 256; i++) begin pmem[i] = '0; exp_mem[i] = '0; end

  always @(posedge clk) begin
    p_ack <= 1'b0;
    if (p_req) begin
      p_ack <= 1'b1;
      if (p_we) pmem[p_addr] <= p_wdata;
      else      p_rdata <= pmem[p_addr];
    end
  end

  typedef struct {
    bit         rd;
    logic [7:0] data;
    string      req;
  } item_t;
  item_t sb[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && h_ack) begin
      if (sb.size() == 0) chk("R2", "unexpected h_ack", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        if (it.rd) chk(it.req, "h_rdata", int'(h_rdata), int'(it.data));
      end
    end
  end

  task automatic host(input bit we, input logic [7:0] a, input logic [7:0] d, input string req);
    int  mi;
    bit  mapped, blk;
    item_t it;
    mi     = int'(a[7:5]);
    mapped = mi < 4;
    blk    = mapped && m_lock[mi];
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_wdata = d;
    it.rd = !we; it.data = blk ? 8'h00 : exp_mem[a]; it.req = req;
    sb.push_back(it);
    if (we && !blk) exp_mem[a] = d;
    #1;
    chk(req, "p_req", int'(p_req), int'(!blk));
    chk(req, "p_sel", int'(p_sel), (mapped && !blk) ? (1 << mi) : 0);
    @(negedge clk);
    h_req = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic set_lock(input logic [3:0] v);
    @(negedge clk);
    c_lock_we = 1'b1; c_lock_wdata = v;
    @(negedge clk);
    c_lock_we = 1'b0;
    m_lock = v;
    chk("R9", "lock", int'(lock), int'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lock after reset", int'(lock), 0);
    chk("R1", "viol after reset", int'(viol), 0);

    host(1'b1, 8'h05, 8'h11, "R2");
    host(1'b1, 8'h2A, 8'h22, "R2");
    host(1'b1, 8'h47, 8'h33, "R2");
    host(1'b1, 8'h6C, 8'h44, "R2");
    host(1'b0, 8'h2A, 8'h00, "R2");
    host(1'b0, 8'h6C, 8'h00, "R2");

    set_lock(4'b0010);
    host(1'b1, 8'h2A, 8'h99, "R3");
    chk("R5", "viol after blocked write", int'(viol), 4'b0010);
    host(1'b0, 8'h2A, 8'h00, "R4");
    host(1'b0, 8'h47, 8'h00, "R10");
    host(1'b1, 8'h05, 8'h55, "R10");
    chk("R10", "viol unchanged by other modules", int'(viol), 4'b0010);

    set_lock(4'b0000);
    host(1'b0, 8'h2A, 8'h00, "R3");
    host(1'b0, 8'h05, 8'h00, "R2");

    set_lock(4'b1111);
    host(1'b1, 8'hA3, 8'h77, "R8");
    host(1'b0, 8'hA3, 8'h00, "R8");
    host(1'b0, 8'hE0, 8'h00, "R8");
    chk("R8", "viol after unmapped accesses", int'(viol), 4'b0010);

    host(1'b0, 8'h47, 8'h00, "R4");
    chk("R5", "viol module 2 raised", int'(viol), 4'b0110);
    @(negedge clk); c_viol_clr = 4'b0010;
    @(negedge clk); c_viol_clr = 4'b0000;
    chk("R6", "selective clear", int'(viol), 4'b0100);
    repeat (3) @(negedge clk);
    chk("R6", "sticky without clear", int'(viol), 4'b0100);

    host(1'b1, 8'h61, 8'hEE, "R3");
    chk("R5", "viol module 3 raised", int'(viol), 4'b1100);
    begin
      item_t it;
      @(negedge clk);
      c_viol_clr = 4'b1000;
      h_req = 1'b1; h_we = 1'b1; h_addr = 8'h61; h_wdata = 8'hEF;
      it.rd = 1'b0; it.data = 8'h00; it.req = "R7";
      sb.push_back(it);
      @(negedge clk);
      c_viol_clr = 4'b0000; h_req = 1'b0;
      chk("R7", "set wins over clear", int'(viol), 4'b1100);
      while (sb.size() != 0) @(negedge clk);
    end

    set_lock(4'b0000);
    host(1'b0, 8'h61, 8'h00, "R3");
    host(1'b0, 8'h6C, 8'h00, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule